// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack and Banked Flags

This block drives the program counter of a small 8-bit core. It holds a 12-bit PC and a six-level hardware return stack that shifts entries up and down instead of moving a pointer. Each cycle, a 3-bit command selects one of these actions: step the PC, jump, branch relative, call, return, return from interrupt, interrupt entry or non-maskable entry. Target addresses, branch offsets and vectors come in on their own ports.

The block also keeps three carry/zero flag pairs, one for each execution context: normal, interrupt and non-maskable. Entering an interrupt or a non-maskable interrupt switches to that context's pair. Return from interrupt switches back to the pair that was active before the entry. The ALU sends flag updates, and they go to the active pair only. A small history of contexts lets nested entries unwind in order. A push beyond the sixth level discards the oldest entry. A pop from an empty stack does nothing to the stack and steps the PC.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, the PC becomes 0xFFE, the stack becomes empty, the context becomes non-maskable (history empty) and all six flags become 0.
- R2: Command 0 (step) makes the next PC equal to PC+1, modulo 4096 (0xFFF steps to 0x000).
- R3: Command 1 (jump) loads target. Command 6 (interrupt entry) and command 7 (non-maskable entry) load vector.
- R4: Command 2 (branch) loads PC plus offset, where offset is an 8-bit two's complement value, modulo 4096.
- R5: Command 3 (call) loads target and pushes PC+1. Command 4 (return) on a non-empty stack loads the most recently pushed address. Addresses come back in last-in first-out order.
- R6: Commands 3, 6 and 7 push PC+1. When six entries are already held, a push discards the oldest, so the depth never exceeds six.
- R7: Command 4 or command 5 on an empty stack leaves the stack empty and makes the next PC equal to PC+1.
- R8: When flag_we is high, carry_in and zero_in are written at the edge into the pair of the context active before that edge. The carry and zero outputs always show the active context's pair.
- R9: Command 6 selects the interrupt pair and command 7 selects the non-maskable pair. Context switches never alter a stored pair.
- R10: Command 5 (return from interrupt) restores the context that was active before the most recent unreturned entry, and pops the address stack as command 4 does. With no entry recorded, it selects the normal context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Command: 0 step, 1 jump, 2 branch, 3 call, 4 return, 5 return from interrupt, 6 interrupt entry, 7 non-maskable entry |
| target | input | 12 | Jump or call destination |
| offset | input | 8 | Signed branch displacement |
| vector | input | 12 | Entry address for commands 6 and 7 |
| flag_we | input | 1 | Write carry_in and zero_in into the active pair |
| carry_in | input | 1 | Carry from the ALU |
| zero_in | input | 1 | Zero from the ALU |
| pc | output | 12 | Program counter |
| carry | output | 1 | Carry of the active context |
| zero | output | 1 | Zero of the active context |

## Verification
A directed prologue first returns from an empty stack right after reset. This shows whether a pop with nothing stored steps the PC or loads stale data. Seven calls followed by seven returns show whether saturation drops the oldest address rather than wrapping onto a valid-looking one. A negative branch near address zero shows whether the PC wraps and the offset is sign-extended. Nested interrupt and non-maskable entries with flag writes in each context, unwound by returns from interrupt, separate flag loss on a context switch from a wrong restore order. A long run of seeded random commands and flag writes then mixes deep pushes, empty pops and context changes in orders the directed cases miss.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW        = 12,
  parameter int LEVELS    = 6,
  parameter int OFFW      = 8,
  parameter int RESET_VEC = 'hFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd,
  input  logic [AW-1:0]   target,
  input  logic [OFFW-1:0] offset,
  input  logic [AW-1:0]   vector,
  input  logic            flag_we,
  input  logic            carry_in,
  input  logic            zero_in,
  output logic [AW-1:0]   pc,
  output logic            carry,
  output logic            zero
);
  localparam int DW = $clog2(LEVELS + 1);
  localparam logic [DW-1:0] FULL = DW'(LEVELS);

  localparam logic [2:0] C_STEP = 3'd0, C_JUMP = 3'd1, C_BRA  = 3'd2, C_CALL = 3'd3,
                         C_RET  = 3'd4, C_RETI = 3'd5, C_IRQ  = 3'd6, C_NMI  = 3'd7;
  localparam logic [1:0] M_NORM = 2'd0, M_IRQ = 2'd1, M_NMI = 2'd2;

  logic [AW-1:0] stk   [LEVELS];
  logic [1:0]    mhist [LEVELS];
  logic [DW-1:0] depth, mdepth;
  logic [1:0]    mode;
  logic [2:0]    cf, zf;
  logic [AW-1:0] pc_next;

  wire [AW-1:0] pc_inc  = pc + AW'(1);
  wire [AW-1:0] off_ext = {{(AW-OFFW){offset[OFFW-1]}}, offset};
  wire entry  = (cmd == C_IRQ) || (cmd == C_NMI);
  wire push   = entry || (cmd == C_CALL);
  wire pop    = (cmd == C_RET) || (cmd == C_RETI);
  wire pop_ok = pop && (depth != '0);

  always_comb begin
    case (cmd)
      C_JUMP, C_CALL: pc_next = target;
      C_BRA:          pc_next = pc + off_ext;
      C_IRQ, C_NMI:   pc_next = vector;
      C_RET, C_RETI:  pc_next = pop_ok ? stk[0] : pc_inc;
      default:        pc_next = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= AW'(RESET_VEC);
      depth  <= '0;
      mdepth <= '0;
      mode   <= M_NMI;
      cf     <= '0;
      zf     <= '0;
      for (int i = 0; i < LEVELS; i++) begin
        stk[i]   <= '0;
        mhist[i] <= M_NORM;
      end
    end else begin
      pc <= pc_next;

      if (push) begin
        stk[0] <= pc_inc;
        for (int i = 1; i < LEVELS; i++) stk[i] <= stk[i-1];
        if (depth != FULL) depth <= depth + DW'(1);
      end else if (pop_ok) begin
        for (int i = 0; i < LEVELS - 1; i++) stk[i] <= stk[i+1];
        stk[LEVELS-1] <= '0;
        depth <= depth - DW'(1);
      end

      if (entry) begin
        mhist[0] <= mode;
        for (int i = 1; i < LEVELS; i++) mhist[i] <= mhist[i-1];
        if (mdepth != FULL) mdepth <= mdepth + DW'(1);
        mode <= (cmd == C_IRQ) ? M_IRQ : M_NMI;
      end else if (cmd == C_RETI) begin
        if (mdepth != '0) begin
          mode <= mhist[0];
          for (int i = 0; i < LEVELS - 1; i++) mhist[i] <= mhist[i+1];
          mhist[LEVELS-1] <= M_NORM;
          mdepth <= mdepth - DW'(1);
        end else begin
          mode <= M_NORM;
        end
      end

      for (int k = 0; k < 3; k++) begin
        if (flag_we && mode == 2'(k)) begin
          cf[k] <= carry_in;
          zf[k] <= zero_in;
        end
      end
    end
  end

  assign carry = (mode == M_IRQ) ? cf[1] : (mode == M_NMI) ? cf[2] : cf[0];
  assign zero  = (mode == M_IRQ) ? zf[1] : (mode == M_NMI) ? zf[2] : zf[0];
endmodule

// File: rtl/pc_sequencer_checker.sv
module pc_sequencer_checker #(
  parameter int AW        = 12,
  parameter int LEVELS    = 6,
  parameter int OFFW      = 8,
  parameter int RESET_VEC = 'hFFE,
  parameter int DW        = $clog2(LEVELS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      cmd,
  input logic [AW-1:0]   target,
  input logic [OFFW-1:0] offset,
  input logic [AW-1:0]   vector,
  input logic [AW-1:0]   pc,
  input logic [DW-1:0]   depth,
  input logic [1:0]      mode
);
  wire [AW-1:0] sext = {{(AW-OFFW){offset[OFFW-1]}}, offset};
  wire pushing = (cmd == 3'd3) || (cmd == 3'd6) || (cmd == 3'd7);
  wire popping = (cmd == 3'd4) || (cmd == 3'd5);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc == AW'(RESET_VEC) && depth == '0 && mode == 2'd2));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd0 |=> pc == $past(pc) + AW'(1));
  a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd1 |=> pc == $past(target));
  a_r3_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6 || cmd == 3'd7) |=> pc == $past(vector));
  a_r4_branch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd2 |=> pc == $past(pc + sext));
  a_r5_call: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd3 |=> pc == $past(target));
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(LEVELS));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pushing && depth == DW'(LEVELS)) |=> depth == DW'(LEVELS));
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (popping && depth == '0) |=> (pc == $past(pc) + AW'(1) && depth == '0));
  a_r9_irq_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd6 |=> mode == 2'd1);
  a_r9_nmi_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd7 |=> mode == 2'd2);
endmodule

bind pc_sequencer pc_sequencer_checker #(
  .AW(AW), .LEVELS(LEVELS), .OFFW(OFFW), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .target(target), .offset(offset),
  .vector(vector), .pc(pc), .depth(depth), .mode(mode)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [11:0] target = '0;
  logic [7:0]  offset = '0;
  logic [11:0] vector = '0;
  logic        flag_we = 1'b0, carry_in = 1'b0, zero_in = 1'b0;
  logic [11:0] pc;
  logic        carry, zero;

  int checks = 0, fails = 0;

  logic [11:0] m_pc;
  logic [11:0] m_stk [6];
  int          m_dep;
  int          m_mode;
  int          m_mh [6];
  int          m_md;
  logic        m_c [3];
  logic        m_z [3];

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .target(target), .offset(offset),
    .vector(vector), .flag_we(flag_we), .carry_in(carry_in), .zero_in(zero_in),
    .pc(pc), .carry(carry), .zero(zero)
  );

  always #4 clk = ~clk;

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 12'hFFE; m_dep = 0; m_mode = 2; m_md = 0;
    for (int i = 0; i < 6; i++) begin m_stk[i] = '0; m_mh[i] = 0; end
    for (int k = 0; k < 3; k++) begin m_c[k] = 1'b0; m_z[k] = 1'b0; end
  endtask

  task automatic model_step(logic [2:0] c, logic [11:0] t, logic [7:0] o,
                            logic [11:0] v, logic we, logic ci, logic zi);
    logic [11:0] inc, npc;
    inc = m_pc + 12'd1;
    npc = inc;
    if (we) begin m_c[m_mode] = ci; m_z[m_mode] = zi; end
    case (c)
      3'd1: npc = t;
      3'd2: npc = m_pc + {{4{o[7]}}, o};
      3'd3, 3'd6, 3'd7: begin
        npc = (c == 3'd3) ? t : v;
        for (int i = 5; i > 0; i--) m_stk[i] = m_stk[i-1];
        m_stk[0] = inc;
        if (m_dep < 6) m_dep++;
      end
      3'd4, 3'd5: if (m_dep > 0) begin
        npc = m_stk[0];
        for (int i = 0; i < 5; i++) m_stk[i] = m_stk[i+1];
        m_dep--;
      end
      default: npc = inc;
    endcase
    if (c == 3'd6 || c == 3'd7) begin
      for (int i = 5; i > 0; i--) m_mh[i] = m_mh[i-1];
      m_mh[0] = m_mode;
      if (m_md < 6) m_md++;
      m_mode = (c == 3'd6) ? 1 : 2;
    end else if (c == 3'd5) begin
      if (m_md > 0) begin
        m_mode = m_mh[0];
        for (int i = 0; i < 5; i++) m_mh[i] = m_mh[i+1];
        m_md--;
      end else m_mode = 0;
    end
    m_pc = npc;
  endtask

  task automatic compare(string tag);
    checks++;
    if (pc !== m_pc) begin
      fails++;
      $display("FAIL %s pc: got %h expected %h", tag, pc, m_pc);
    end
    checks++;
    if (carry !== m_c[m_mode] || zero !== m_z[m_mode]) begin
      fails++;
      $display("FAIL R8 flags after %s: got c=%b z=%b expected c=%b z=%b",
               tag, carry, zero, m_c[m_mode], m_z[m_mode]);
    end
  endtask

  task automatic run(logic [2:0] c, logic [11:0] t, logic [7:0] o, logic [11:0] v,
                     logic we, logic ci, logic zi, string tag);
    cmd = c; target = t; offset = o; vector = v;
    flag_we = we; carry_in = ci; zero_in = zi;
    model_step(c, t, o, v, we, ci, zi);
    @(negedge clk);
    compare(tag == "" ? tag_of(c) : tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R7: pops on an empty stack right after reset
    run(3'd4, 12'h123, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R7");
    // R10: return from interrupt with empty history selects normal context
    run(3'd5, 12'h000, 8'h00, 12'h000, 1'b1, 1'b1, 1'b0, "R10");
    run(3'd0, 12'h000, 8'h00, 12'h000, 1'b1, 1'b0, 1'b1, "R8");
    // R4: negative branch wrapping below zero
    run(3'd1, 12'h002, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R3");
    run(3'd2, 12'h000, 8'hFB, 12'h000, 1'b0, 1'b0, 1'b0, "R4");
    run(3'd2, 12'h000, 8'h7F, 12'h000, 1'b0, 1'b0, 1'b0, "R4");
    // R6: seven calls then seven returns, the last acting on an empty stack
    for (int i = 0; i < 7; i++)
      run(3'd3, 12'h100 + 12'(i * 16), 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 7; i++)
      run(3'd4, 12'h000, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, i == 6 ? "R7" : "R6");
    // R9/R10: nested contexts with flag writes in each
    run(3'd6, 12'h000, 8'h00, 12'h040, 1'b1, 1'b1, 1'b1, "R9");
    run(3'd0, 12'h000, 8'h00, 12'h000, 1'b1, 1'b0, 1'b1, "R8");
    run(3'd7, 12'h000, 8'h00, 12'hFFC, 1'b0, 1'b0, 1'b0, "R9");
    run(3'd0, 12'h000, 8'h00, 12'h000, 1'b1, 1'b1, 1'b0, "R8");
    run(3'd5, 12'h000, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R10");
    run(3'd5, 12'h000, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R10");
    run(3'd7, 12'h000, 8'h00, 12'hFFC, 1'b0, 1'b0, 1'b0, "R9");
    run(3'd5, 12'h000, 8'h00, 12'h000, 1'b0, 1'b0, 1'b0, "R10");

    for (int n = 0; n < 4000; n++)
      run(3'($urandom_range(0, 7)), 12'($urandom), 8'($urandom), 12'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), "");

    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule